// File: doc/BRIEF.md
# Dual Multi-Mode Counter/Timer

The block holds two identical up-counters, each built from a low and a high count byte. Software configures them through a byte-wide register port. Each timer has a 4-bit configuration nibble: a gate enable, a source select and a 2-bit structure field. Each timer also has a run bit and an overflow flag.

The structure field picks one of four arrangements of the two count bytes:
- a 13-bit prescaled counter,
- a plain 16-bit counter,
- an 8-bit counter that reloads itself from the high byte,
- a split arrangement in which timer 0 becomes two independent 8-bit counters.

A timer advances on one of three tick sources: every clock, one clock in twelve, or each falling edge of its event pin. With the gate enabled, a timer advances only while its interrupt pin is high. The overflow flags drive outputs toward an interrupt controller. An acknowledge pulse from that controller clears a flag, and software can also clear it.

Top module: `ct_pair`

## Requirements
- R1: After reset every readable register, both count byte pairs and both overflow flags read zero.
- R2: Address map: 0 = configuration (timer 1 nibble in bits 7:4, timer 0 nibble in bits 3:0, each nibble {gate, source, mode[1:0]}), 1 = control (bit 7 flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0, bits 3:0 read 0), 2 = rate select (bit i = 1 gives timer i every clock), 4/5 = timer 0 low/high, 6/7 = timer 1 low/high, 3 reads 0.
- R3: With source 0 and rate bit 1 the timer advances each clock. With rate bit 0 it advances exactly once per 12 clocks, counted by a free-running divider.
- R4: Mode 01 counts the 16-bit value {high, low}. A wrap from FFFFh to 0000h sets the timer's flag.
- R5: Mode 00 counts a 13-bit value made of the high byte and low bits 4:0. A carry out of bit 4 advances the high byte, low bits 7:5 keep their value, and a wrap to zero sets the flag.
- R6: Mode 10 advances only the low byte. On the FFh-to-00h step the flag sets and the low byte takes the high byte's value on that same tick.
- R7: With gate = 1 a running timer advances only while its interrupt pin is high. With gate = 0 the pin has no effect.
- R8: With source = 1 the timer advances once per high-to-low transition of its event pin. The pin passes through a two-stage synchronizer, so a count lands on the third clock edge after the pin falls. Steady levels and rising edges do not count.
- R9: In timer 0 mode 11, the low byte uses timer 0's run, gate and source and sets flag 0. The high byte advances at timer 0's clock rate under run bit 1 and sets flag 1. Timer 1 holds its count.
- R10: Writing 0 to a flag bit clears it, writing 1 leaves it unchanged, and an acknowledge pulse clears it. A hardware overflow in the same cycle wins over both.
- R11: A write to a count byte in the same cycle as an advance of that byte takes the written value, and that advance is discarded.
- R12: With its run bit 0 a timer's count bytes keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_pin | input | 2 | Per-timer gate pins, active high |
| evt_pin | input | 2 | Per-timer external event pins |
| irq_ack | input | 2 | Per-timer flag acknowledge pulses |
| ovf_flag | output | 2 | Per-timer overflow flags |

## Verification
The assertions take the gate pins and the acknowledge inputs to be synchronous to the clock and free of glitches. Only the event pins are treated as asynchronous. The bench drives every input at the falling clock edge and changes each event pin only after it has held for several cycles, so the synchronizer always sees a clean level. The assertions also take as given that the configuration and count bytes change only through the register port. The bench never forces reset mid-run, and it leaves enough idle time between tests for any pending edge detection to drain.

// File: rtl/ct_pkg.sv
// Package: shared types and register map constants for the dual counter/timer.
// Assumes: an 8-bit register port with a 3-bit address.
package ct_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NTMR   = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext;
        tmode_e mode;
    } tcfg_t;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RATE = 3'd2;
    localparam logic [ADDR_W-1:0] A_T0LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_T0HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_T1LO = 3'd6;
    localparam logic [ADDR_W-1:0] A_T1HI = 3'd7;

    // control register: run bit of timer i at 4+2i, flag at 5+2i
    localparam int CTL_BASE = 4;
endpackage

// File: rtl/ct_prescale.sv
// Module: free-running clock divider.
// Produces a one-cycle pulse every DIV clocks. Assumes DIV >= 2.
module ct_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    // Wrap the divider count at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ct_edge.sv
// Module: synchronizer and falling-edge detector for N asynchronous pins.
// Two flops resynchronize each pin. A third flop holds the previous sample,
// so a fall is flagged when the previous sample is high and the current one is low.
module ct_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic [N-1:0] s1_q, s2_q, s3_q;

    // Shift the pin samples through the synchronizer and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall = s3_q & ~s2_q;
endmodule

// File: rtl/ct_core.sv
// Module: one timer's count byte pair and its four count structures.
// inc_main advances the main counter and inc_aux the split-mode high byte.
// A byte write in the same cycle replaces the byte and cancels that advance.
// With SPLIT_OK = 0, mode 11 holds the count.
module ct_core
    import ct_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  tmode_e mode,
    input  logic   inc_main,
    input  logic   inc_aux,
    input  logic   wr_lo,
    input  logic   wr_hi,
    input  byte_t  wr_data,
    output byte_t  cnt_lo,
    output byte_t  cnt_hi,
    output logic   ovf_main,
    output logic   ovf_aux
);
    byte_t lo_n, hi_n;
    logic  step_main;

    assign step_main = inc_main && !wr_lo && !wr_hi;

    // Next-count selection for the current structure, writes last.
    always_comb begin
        lo_n     = cnt_lo;
        hi_n     = cnt_hi;
        ovf_main = 1'b0;
        ovf_aux  = 1'b0;
        unique case (mode)
            MODE_13: begin
                if (step_main) begin
                    if (cnt_lo[4:0] == 5'h1F) begin
                        lo_n[4:0] = 5'h00;
                        hi_n      = cnt_hi + 8'd1;
                        ovf_main  = (cnt_hi == 8'hFF);
                    end else begin
                        lo_n[4:0] = cnt_lo[4:0] + 5'd1;
                    end
                end
            end
            MODE_16: begin
                if (step_main) begin
                    {hi_n, lo_n} = {cnt_hi, cnt_lo} + 16'd1;
                    ovf_main     = (cnt_hi == 8'hFF) && (cnt_lo == 8'hFF);
                end
            end
            MODE_RELOAD: begin
                if (step_main) begin
                    if (cnt_lo == 8'hFF) begin
                        lo_n     = cnt_hi;
                        ovf_main = 1'b1;
                    end else begin
                        lo_n = cnt_lo + 8'd1;
                    end
                end
            end
            MODE_SPLIT: begin
                if (SPLIT_OK) begin
                    if (inc_main && !wr_lo) begin
                        lo_n     = cnt_lo + 8'd1;
                        ovf_main = (cnt_lo == 8'hFF);
                    end
                    if (inc_aux && !wr_hi) begin
                        hi_n    = cnt_hi + 8'd1;
                        ovf_aux = (cnt_hi == 8'hFF);
                    end
                end
            end
            default: ;
        endcase
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    // Register the count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            cnt_lo <= lo_n;
            cnt_hi <= hi_n;
        end
    end
endmodule

// File: rtl/ct_pair.sv
// Module: top of the dual multi-mode counter/timer.
// Holds the configuration, control and rate registers, forms each timer's
// advance enable from run, gate, source and rate, and owns the overflow flags.
// Assumes irq_pin and irq_ack are synchronous to clk. evt_pin may be asynchronous.
module ct_pair
    import ct_pkg::*;
#(
    parameter int PRESCALE = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    input  logic [NTMR-1:0]      irq_pin,
    input  logic [NTMR-1:0]      evt_pin,
    input  logic [NTMR-1:0]      irq_ack,
    output logic [NTMR-1:0]      ovf_flag
);
    byte_t           mode_r;
    logic [NTMR-1:0] tr_r, tf_r, fast_r;
    logic [NTMR-1:0] tf_set, evt_fall, base_tick, src_tick, run;
    tcfg_t           cfg [NTMR];
    logic            pre_tick, split;
    logic            t0_wr_lo, t0_wr_hi, t1_wr_lo, t1_wr_hi, t0_wr, t1_wr;
    byte_t           t0_lo, t0_hi, t1_lo, t1_hi;
    logic            t0_ovf, t0_ovf_aux, t1_ovf, t1_ovf_aux;

    ct_prescale #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick)
    );

    ct_edge #(.N(NTMR)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(evt_pin), .fall(evt_fall)
    );

    // Per-timer configuration decode and tick qualification.
    for (genvar i = 0; i < NTMR; i++) begin : g_tick
        assign cfg[i]       = tcfg_t'(mode_r[4*i +: 4]);
        assign base_tick[i] = fast_r[i] | pre_tick;
        assign src_tick[i]  = cfg[i].ext ? evt_fall[i] : base_tick[i];
        assign run[i]       = tr_r[i] & (~cfg[i].gate | irq_pin[i]);
    end

    assign split    = (cfg[0].mode == MODE_SPLIT);
    assign t0_wr_lo = wr_en && (wr_addr == A_T0LO);
    assign t0_wr_hi = wr_en && (wr_addr == A_T0HI);
    assign t1_wr_lo = wr_en && (wr_addr == A_T1LO);
    assign t1_wr_hi = wr_en && (wr_addr == A_T1HI);
    assign t0_wr    = t0_wr_lo | t0_wr_hi;
    assign t1_wr    = t1_wr_lo | t1_wr_hi;

    ct_core #(.SPLIT_OK(1'b1)) u_t0 (
        .clk(clk), .rst_n(rst_n), .mode(cfg[0].mode),
        .inc_main(run[0] & src_tick[0]),
        .inc_aux(tr_r[1] & base_tick[0]),
        .wr_lo(t0_wr_lo), .wr_hi(t0_wr_hi), .wr_data(wr_data),
        .cnt_lo(t0_lo), .cnt_hi(t0_hi),
        .ovf_main(t0_ovf), .ovf_aux(t0_ovf_aux)
    );

    ct_core #(.SPLIT_OK(1'b0)) u_t1 (
        .clk(clk), .rst_n(rst_n), .mode(cfg[1].mode),
        .inc_main(run[1] & src_tick[1] & ~split),
        .inc_aux(1'b0),
        .wr_lo(t1_wr_lo), .wr_hi(t1_wr_hi), .wr_data(wr_data),
        .cnt_lo(t1_lo), .cnt_hi(t1_hi),
        .ovf_main(t1_ovf), .ovf_aux(t1_ovf_aux)
    );

    assign tf_set[0] = t0_ovf;
    assign tf_set[1] = split ? t0_ovf_aux : t1_ovf;

    // Configuration, run and rate registers loaded from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
            tr_r   <= '0;
            fast_r <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CFG)  mode_r <= wr_data;
            if (wr_addr == A_RATE) fast_r <= wr_data[NTMR-1:0];
            if (wr_addr == A_CTL)
                for (int i = 0; i < NTMR; i++) tr_r[i] <= wr_data[CTL_BASE + 2*i];
        end
    end

    // Overflow flags: hardware set, then acknowledge, then software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_r <= '0;
        end else begin
            for (int i = 0; i < NTMR; i++) begin
                if (tf_set[i])
                    tf_r[i] <= 1'b1;
                else if (irq_ack[i])
                    tf_r[i] <= 1'b0;
                else if (wr_en && (wr_addr == A_CTL) && !wr_data[CTL_BASE + 2*i + 1])
                    tf_r[i] <= 1'b0;
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CFG:   rd_data = mode_r;
            A_CTL:   rd_data = {tf_r[1], tr_r[1], tf_r[0], tr_r[0], 4'b0000};
            A_RATE:  rd_data = {{(BYTE_W-NTMR){1'b0}}, fast_r};
            A_T0LO:  rd_data = t0_lo;
            A_T0HI:  rd_data = t0_hi;
            A_T1LO:  rd_data = t1_lo;
            A_T1HI:  rd_data = t1_hi;
            default: rd_data = '0;
        endcase
    end

    assign ovf_flag = tf_r;
endmodule

// File: rtl/ct_pair_chk.sv
// Module: temporal checks on ct_pair, attached by bind.
// Assumes the count bytes change only through the core update or the write port.
module ct_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode0,
    input logic [1:0] tr,
    input logic [1:0] tf,
    input logic [1:0] tf_set,
    input logic [1:0] ack,
    input logic [7:0] t0_lo,
    input logic [7:0] t0_hi,
    input logic [7:0] t1_lo,
    input logic [7:0] t1_hi,
    input logic       t0_wr,
    input logic       t1_wr,
    input logic       t0_ovf,
    input logic       split,
    input logic       pre_tick
);
    // R3: the divider pulse never lasts two cycles
    p_prescale_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |=> !pre_tick);

    // R6: reload copies the high byte into the low byte
    p_reload_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 2'b10 && t0_ovf && !t0_wr) |=> (t0_lo == $past(t0_hi)));

    // R9: timer 1 frozen while timer 0 is split
    p_split_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !t1_wr) |=> $stable({t1_hi, t1_lo}));

    // R10: an overflow always leaves the flag set
    p_flag_set0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tf_set[0] |=> tf[0]);
    p_flag_set1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tf_set[1] |=> tf[1]);

    // R10: acknowledge without overflow clears the flag
    p_ack_clear0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && !tf_set[0]) |=> !tf[0]);
    p_ack_clear1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[1] && !tf_set[1]) |=> !tf[1]);

    // R12: a stopped, unwritten, non-split timer 0 keeps its count
    p_stop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tr[0] && mode0 != 2'b11 && !t0_wr) |=> $stable({t0_hi, t0_lo}));
endmodule

bind ct_pair ct_pair_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode0(mode_r[1:0]), .tr(tr_r), .tf(tf_r),
    .tf_set(tf_set), .ack(irq_ack), .t0_lo(t0_lo), .t0_hi(t0_hi),
    .t1_lo(t1_lo), .t1_hi(t1_hi), .t0_wr(t0_wr), .t1_wr(t1_wr),
    .t0_ovf(t0_ovf), .split(split), .pre_tick(pre_tick)
);

// File: tb/ct_pair_test.sv
// Bench: scoreboard for ct_pair. The driver pushes expected register reads
// into a queue, and a monitor process pops, reads and compares them.
module ct_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] irq_pin = '0;
    logic [1:0] evt_pin = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] ovf_flag;

    localparam logic [2:0] CFG = 3'd0, CTL = 3'd1, RATE = 3'd2;
    localparam logic [2:0] T0L = 3'd4, T0H = 3'd5, T1L = 3'd6, T1H = 3'd7;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int n_push = 0, n_done = 0, n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ct_pair uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_pin(irq_pin), .evt_pin(evt_pin), .irq_ack(irq_ack),
        .ovf_flag(ovf_flag)
    );

    // One register write; starts and ends at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue an expected read and wait for the monitor.
    task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        n_push++;
        wait (n_done == n_push);
    endtask

    // Monitor: pop expected items, read the register and compare.
    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            it = q.pop_front();
            rd_addr = it.addr;
            #1;
            n_checks++;
            if (rd_data !== it.exp) begin
                n_fail++;
                $display("FAIL %s: addr %0d actual %02h expected %02h",
                         it.tag, it.addr, rd_data, it.exp);
            end
            n_done++;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'h00, "R1 reset");

        // R2 map and readback
        wr(CFG, 8'hA5);
        expect_rd(CFG, 8'hA5, "R2 config readback");
        wr(CTL, 8'h5F);
        expect_rd(CTL, 8'h50, "R2 control run bits, low nibble zero");
        wr(RATE, 8'hFF);
        expect_rd(RATE, 8'h03, "R2 rate bits");
        wr(CTL, 8'hA0);
        expect_rd(CTL, 8'h00, "R2 run cleared");
        expect_rd(T0L, 8'h00, "R12 no count without ticks");

        // R4 16-bit wrap on timer 0, fast rate (R3)
        wr(CFG, 8'h01); wr(RATE, 8'h01);
        wr(T0L, 8'hFE); wr(T0H, 8'hFF);
        wr(CTL, 8'h10); idle(2); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h01, "R4 low after wrap");
        expect_rd(T0H, 8'h00, "R4 high after wrap");
        expect_rd(CTL, 8'h20, "R4 flag 0 set");
        irq_ack = 2'b01; idle(1); irq_ack = 2'b00;
        expect_rd(CTL, 8'h00, "R10 acknowledge clears flag 0");

        // R3 divide-by-12: 60 clocks give 5 counts
        wr(RATE, 8'h00); wr(T0L, 8'h00); wr(T0H, 8'h00);
        wr(CTL, 8'h10); idle(59); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h05, "R3 prescaled count");

        // R5 13-bit structure
        wr(CFG, 8'h00); wr(RATE, 8'h01);
        wr(T0L, 8'hFE); wr(T0H, 8'hFF);
        wr(CTL, 8'h10); idle(1); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'hE0, "R5 low bits 7:5 kept");
        expect_rd(T0H, 8'h00, "R5 high wrapped");
        expect_rd(CTL, 8'h20, "R5 flag on 13-bit wrap");
        wr(CTL, 8'h00);
        expect_rd(CTL, 8'h00, "R10 software clear");
        wr(T0L, 8'h1F); wr(T0H, 8'h12);
        wr(CTL, 8'h10); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h00, "R5 carry out of bit 4");
        expect_rd(T0H, 8'h13, "R5 high advanced");
        expect_rd(CTL, 8'h00, "R5 no flag without full wrap");

        // R6 auto-reload
        wr(CFG, 8'h02); wr(T0L, 8'hFD); wr(T0H, 8'h80);
        wr(CTL, 8'h10); idle(3); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h81, "R6 reload then advance");
        expect_rd(T0H, 8'h80, "R6 reload byte kept");
        expect_rd(CTL, 8'h20, "R6 flag on reload");
        idle(10);
        expect_rd(T0L, 8'h81, "R12 stopped timer holds");
        wr(CTL, 8'h00);

        // R7 gate
        wr(CFG, 8'h09); wr(T0L, 8'h00); wr(T0H, 8'h00);
        irq_pin = 2'b00;
        wr(CTL, 8'h10); idle(5); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h00, "R7 gate pin low blocks");
        irq_pin = 2'b01;
        wr(CTL, 8'h10); idle(3); wr(CTL, 8'hA0);
        irq_pin = 2'b00;
        expect_rd(T0L, 8'h04, "R7 gate pin high counts");

        // R8 external event edges
        wr(CFG, 8'h05); wr(T0L, 8'h00);
        wr(CTL, 8'h10);
        for (int k = 0; k < 4; k++) begin
            evt_pin[0] = 1'b1; idle(3);
            evt_pin[0] = 1'b0; idle(3);
        end
        idle(4);
        evt_pin[0] = 1'b1; idle(10);
        wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h04, "R8 falling edges counted, level and rise ignored");
        evt_pin[0] = 1'b0; idle(5);
        expect_rd(T0L, 8'h04, "R8 edge while stopped ignored");

        // R9 split operation
        wr(CFG, 8'h13); wr(RATE, 8'h01);
        wr(T0L, 8'hFE); wr(T0H, 8'hF0); wr(T1L, 8'h33); wr(T1H, 8'h44);
        wr(CTL, 8'h10); idle(1); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h00, "R9 split low byte wrap");
        expect_rd(T0H, 8'hF0, "R9 split high byte idle under run 0");
        expect_rd(CTL, 8'h20, "R9 split low sets flag 0");
        wr(CTL, 8'h60); idle(2); wr(CTL, 8'hA0);
        expect_rd(T0H, 8'hF3, "R9 split high byte under run 1");
        expect_rd(T0L, 8'h00, "R9 split low idle under run 0");
        expect_rd(T1L, 8'h33, "R9 timer 1 held low");
        expect_rd(T1H, 8'h44, "R9 timer 1 held high");
        expect_rd(CTL, 8'h20, "R9 no flag 1 yet");
        wr(T0H, 8'hFF); wr(CTL, 8'h60); wr(CTL, 8'hA0);
        expect_rd(T0H, 8'h00, "R9 split high wrap");
        expect_rd(CTL, 8'hA0, "R9 split high sets flag 1");
        wr(CTL, 8'h00);

        // R4 timer 1 16-bit wrap
        wr(CFG, 8'h10); wr(RATE, 8'h02);
        wr(T1L, 8'hFF); wr(T1H, 8'hFF);
        wr(CTL, 8'h40); wr(CTL, 8'hA0);
        expect_rd(T1L, 8'h00, "R4 timer 1 low wrap");
        expect_rd(CTL, 8'h80, "R4 timer 1 flag");
        if (ovf_flag !== 2'b10) begin
            n_fail++;
            $display("FAIL R4 flag output: actual %b expected 10", ovf_flag);
        end
        n_checks++;
        irq_ack = 2'b10; idle(1); irq_ack = 2'b00;
        expect_rd(CTL, 8'h00, "R10 acknowledge clears flag 1");

        // R11 write beats increment
        wr(CFG, 8'h01); wr(RATE, 8'h01); wr(T0L, 8'h00); wr(T0H, 8'h00);
        wr(CTL, 8'h10); wr(T0L, 8'h40); idle(2); wr(CTL, 8'hA0);
        expect_rd(T0L, 8'h43, "R11 write wins over advance");
        expect_rd(T0H, 8'h00, "R11 high untouched");

        // R10 overflow wins over acknowledge
        wr(CFG, 8'h02); wr(T0L, 8'hFF); wr(T0H, 8'h00); wr(CTL, 8'h00);
        wr(CTL, 8'h10);
        irq_ack = 2'b01; idle(1); irq_ack = 2'b00;
        wr(CTL, 8'hA0);
        expect_rd(CTL, 8'h20, "R10 overflow beats acknowledge");
        expect_rd(T0L, 8'h01, "R6 reload to zero then advance");
        irq_ack = 2'b01; idle(1); irq_ack = 2'b00;
        expect_rd(CTL, 8'h00, "R10 acknowledge alone clears");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule